// File: doc/BRIEF.md
# Split-Option Run-Length Test Vector Decoder

This block rebuilds fixed-width test words from a compressed one-bit stream. Each word of the stream was encoded by cutting off its B lowest bits and sending them raw, then sending the remaining upper value as a run of zeros closed by a single one. The value of B is chosen once per group of words and is sent ahead of the group as a short identifier. The decoder reads that identifier, then for each word gathers the raw low bits, counts the zeros until the closing one, and presents the rebuilt word as (zero count << B) | low bits.

The serial input and the word output each use a valid/ready handshake. While a rebuilt word waits at the output the serial input is held off. A pulse marks the hand-off of the last word of each group. A zero run too long to fit the word leaves a permanent error state that only reset clears.

Top module: `sdv_run_decoder`

## Requirements
- R1: While rst_n is low, in_ready, out_valid, group_done and err are all 0.
- R2: Each group begins with a 3-bit identifier sent most significant bit first, whose unsigned value is B (0 to 7) for all eight words of that group.
- R3: After the identifier (and after each delivered word that is not the last of its group), the next B accepted bits are the word's low bits, most significant first, and the bits after them are counted as zeros until a 1 is accepted.
- R4: The delivered word equals (number of zeros << B) | low bits, truncated to 8 bits; with B = 0 it equals the zero count alone.
- R5: A group holds eight words; group_done is 1 exactly in the cycle the eighth word is handed off (out_valid and out_ready both 1) and 0 otherwise, after which a new identifier is read.
- R6: Once out_valid is 1 it stays 1 with out_word unchanged until out_ready is 1, and in_ready is 0 whenever out_valid is 1.
- R7: A run of zeros of length 255 >> B followed by a 1 decodes normally; a further zero sets err, which then stays 1 with in_ready and out_valid at 0 until reset.
- R8: A bit presented while in_valid is 0 is not consumed and has no effect on the decoded words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_bit | input | 1 | Serial coded bit |
| in_valid | input | 1 | in_bit is valid |
| in_ready | output | 1 | Decoder accepts a bit this cycle |
| out_word | output | 8 | Rebuilt test word |
| out_valid | output | 1 | out_word is valid |
| out_ready | input | 1 | Receiver takes out_word this cycle |
| group_done | output | 1 | Last word of the group is handed off |
| err | output | 1 | Sticky zero-run overflow flag |

## Verification
The bench sweeps every B with the words 0 and 255, so that a run ending exactly at the 255 >> B bound decodes while one more zero trips the error; a decoder with an off-by-one limit either flags a legal word or lets an overflowing run wrap into a wrong value. Words whose low bits are all ones and whose high part is zero catch a decoder that reverses the raw bit order or captures one bit too few or too many. Random input gaps and output stalls expose a design that consumes bits while in_valid is low or that changes or drops a word held at the output, and counting words across groups catches a misplaced group_done or an identifier read at the wrong point.

// File: rtl/sdv_pkg.sv
package sdv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ID,
    ST_RD_LOW,
    ST_CNT,
    ST_EMIT,
    ST_HALT
  } sdv_state_e;

endpackage

// File: rtl/sdv_shift_in.sv
module sdv_shift_in #(
  parameter int W  = 3,
  parameter int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          shift,
  input  logic          din,
  output logic [W-1:0]  val,
  output logic [CW-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val <= '0;
      cnt <= '0;
    end else if (clr) begin
      val <= '0;
      cnt <= '0;
    end else if (shift) begin
      val <= {val[W-2:0], din};
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sdv_zero_count.sv
module sdv_zero_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         at_limit
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign at_limit = (cnt == limit);

endmodule

// File: rtl/sdv_run_decoder.sv
module sdv_run_decoder
  import sdv_pkg::*;
#(
  parameter int WORD_W    = 8,
  parameter int GROUP_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_bit,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              group_done,
  output logic              err
);

  localparam int ID_W   = $clog2(WORD_W);
  localparam int IDC_W  = $clog2(ID_W + 1);
  localparam int LOW_W  = WORD_W - 1;
  localparam int LCNT_W = $clog2(LOW_W + 1);
  localparam int IDX_W  = $clog2(GROUP_LEN);

  // Largest zero count that still fits once shifted up by b.
  function automatic logic [WORD_W-1:0] run_limit(input logic [ID_W-1:0] b);
    return {WORD_W{1'b1}} >> b;
  endfunction

  // Upper part from the zero count, lower b bits from the raw field.
  function automatic logic [WORD_W-1:0] join_word(input logic [WORD_W-1:0] hi,
                                                  input logic [LOW_W-1:0]  lo,
                                                  input logic [ID_W-1:0]   b);
    logic [WORD_W-1:0] mask;
    mask = ~({WORD_W{1'b1}} << b);
    return (hi << b) | ({1'b0, lo} & mask);
  endfunction

  sdv_state_e st, st_nx;

  logic [ID_W-1:0]   id_val;
  logic [IDC_W-1:0]  id_cnt;
  logic [LOW_W-1:0]  low_val;
  logic [LCNT_W-1:0] low_cnt;
  logic [WORD_W-1:0] zcnt;
  logic              at_limit;
  logic [IDX_W-1:0]  word_idx;
  logic [WORD_W-1:0] word_q;

  // Named events for the sequencer and the checks.
  logic acc, id_last, low_last, zero_seen, one_seen, overflow;
  logic out_fire, last_word, group_end;
  logic [ID_W-1:0] new_b;

  assign in_ready  = (st == ST_RD_ID) || (st == ST_RD_LOW) || (st == ST_CNT);
  assign out_valid = (st == ST_EMIT);
  assign err       = (st == ST_HALT);
  assign out_word  = word_q;

  assign acc       = in_valid && in_ready;
  assign id_last   = (st == ST_RD_ID) && acc && (id_cnt == IDC_W'(ID_W - 1));
  assign new_b     = {id_val[ID_W-2:0], in_bit};
  assign low_last  = (st == ST_RD_LOW) && acc && ((int'(low_cnt) + 1) == int'(id_val));
  assign zero_seen = (st == ST_CNT) && acc && !in_bit;
  assign one_seen  = (st == ST_CNT) && acc && in_bit;
  assign overflow  = zero_seen && at_limit;
  assign out_fire  = out_valid && out_ready;
  assign last_word = (word_idx == IDX_W'(GROUP_LEN - 1));
  assign group_end = out_fire && last_word;
  assign group_done = group_end;

  sdv_shift_in #(.W(ID_W), .CW(IDC_W)) u_id (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   ((st == ST_IDLE) || group_end),
    .shift ((st == ST_RD_ID) && acc),
    .din   (in_bit),
    .val   (id_val),
    .cnt   (id_cnt)
  );

  sdv_shift_in #(.W(LOW_W), .CW(LCNT_W)) u_low (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (id_last || out_fire),
    .shift ((st == ST_RD_LOW) && acc),
    .din   (in_bit),
    .val   (low_val),
    .cnt   (low_cnt)
  );

  sdv_zero_count #(.W(WORD_W)) u_zero (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (id_last || out_fire),
    .inc      (zero_seen && !at_limit),
    .limit    (run_limit(id_val)),
    .cnt      (zcnt),
    .at_limit (at_limit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (one_seen) begin
      word_q <= join_word(zcnt, low_val, id_val);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_idx <= '0;
    end else if (out_fire) begin
      word_idx <= last_word ? '0 : word_idx + 1'b1;
    end
  end

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:   st_nx = ST_RD_ID;
      ST_RD_ID:  if (id_last) st_nx = (new_b == '0) ? ST_CNT : ST_RD_LOW;
      ST_RD_LOW: if (low_last) st_nx = ST_CNT;
      ST_CNT: begin
        if (overflow)      st_nx = ST_HALT;
        else if (one_seen) st_nx = ST_EMIT;
      end
      ST_EMIT: begin
        if (out_fire) begin
          if (last_word)           st_nx = ST_RD_ID;
          else if (id_val == '0)   st_nx = ST_CNT;
          else                     st_nx = ST_RD_LOW;
        end
      end
      ST_HALT:   st_nx = ST_HALT;
      default:   st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R6
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!in_ready && !out_valid));

  // R5
  group_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    group_done |=> (in_ready && !out_valid && !err));

  // R4
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CNT) |-> (zcnt <= run_limit(id_val)));

endmodule

// File: tb/sdv_run_decoder_bench.sv
module sdv_run_decoder_bench;

  localparam int W = 8;
  localparam int G = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_bit = 1'b0;
  logic         in_valid = 1'b0;
  logic         out_ready = 1'b0;
  logic         in_ready;
  logic [W-1:0] out_word;
  logic         out_valid;
  logic         group_done;
  logic         err;

  sdv_run_decoder #(.WORD_W(W), .GROUP_LEN(G)) u_sdv_run_decoder (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_bit     (in_bit),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_word   (out_word),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .group_done (group_done),
    .err        (err)
  );

  always #10 clk = ~clk;

  int     checks = 0;
  int     fails = 0;
  int     cyc = 0;
  int     recv = 0;
  bit     bitq[$];
  int     expq[$];
  bit     chk_err = 1'b1;
  bit     pend = 1'b0;
  int     pend_word = 0;
  string  cur_req = "R4";

  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R5 watchdog: actual=%0d expected<%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  // R2: identifier MSB first
  task automatic push_id(input int b);
    for (int i = 2; i >= 0; i--) bitq.push_back(bit'((b >> i) & 1));
  endtask

  // R3: low bits MSB first, then zero run closed by a one
  task automatic push_word(input int b, input int w);
    for (int i = b - 1; i >= 0; i--) bitq.push_back(bit'((w >> i) & 1));
    for (int z = 0; z < (w >> b); z++) bitq.push_back(1'b0);
    bitq.push_back(1'b1);
    expq.push_back(w);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    out_ready = 1'b0;
    bitq.delete();
    expq.delete();
    recv = 0;
    pend = 1'b0;
    repeat (4) @(negedge clk);
    check(in_ready == 1'b0, "R1", in_ready, 0, "in_ready in reset");
    check(out_valid == 1'b0, "R1", out_valid, 0, "out_valid in reset");
    check(err == 1'b0, "R1", err, 0, "err in reset");
    check(group_done == 1'b0, "R1", group_done, 0, "group_done in reset");
    rst_n = 1'b1;
  endtask

  task automatic step(input int gap, input int rdy);
    @(negedge clk);
    in_valid  = (bitq.size() > 0) && ($urandom_range(99) >= gap);
    in_bit    = in_valid ? bitq[0] : 1'($urandom_range(1)); // R8: noise when not valid
    out_ready = ($urandom_range(99) < rdy);
    #1;
    if (pend) check(out_valid && (int'(out_word) == pend_word), "R6", int'(out_word), pend_word, "held word");
    check(!(in_ready && out_valid), "R6", int'(in_ready), 0, "in_ready while word pending");
    if (chk_err) check(err == 1'b0, "R7", err, 0, "spurious error");
    if (in_valid && in_ready) void'(bitq.pop_front());
    if (out_valid && out_ready) begin
      if (expq.size() == 0) begin
        check(1'b0, cur_req, int'(out_word), -1, "unexpected word");
      end else begin
        check(int'(out_word) == expq[0], cur_req, int'(out_word), expq[0], "decoded word");
        check(group_done == ((recv % G) == G - 1), "R5", group_done, int'((recv % G) == G - 1), "group_done at hand-off");
        void'(expq.pop_front());
        recv++;
      end
    end else begin
      check(group_done == 1'b0, "R5", group_done, 0, "group_done without hand-off");
    end
    pend = out_valid && !out_ready;
    pend_word = int'(out_word);
  endtask

  task automatic drain(input int gap, input int rdy);
    while (bitq.size() > 0 || expq.size() > 0) step(gap, rdy);
  endtask

  task automatic rand_group(input int b);
    push_id(b);
    for (int k = 0; k < G; k++) push_word(b, $urandom_range(255));
  endtask

  // R7: boundary run decodes nothing wrong, one more zero halts
  task automatic err_case(input int b);
    int lim;
    do_reset();
    chk_err = 1'b1;
    lim = 255 >> b;
    push_id(b);
    for (int i = 0; i < b; i++) bitq.push_back(1'b1);
    for (int z = 0; z < lim; z++) bitq.push_back(1'b0);
    drain(0, 100);
    step(0, 100);
    step(0, 100);
    check(err == 1'b0, "R7", err, 0, "err at run limit");
    check(in_ready == 1'b1, "R7", in_ready, 1, "still counting at run limit");
    chk_err = 1'b0;
    bitq.push_back(1'b0);
    drain(0, 100);
    step(0, 100);
    check(err == 1'b1, "R7", err, 1, "err after run overflow");
    check(in_ready == 1'b0, "R7", in_ready, 0, "in_ready after overflow");
    for (int i = 0; i < 6; i++) bitq.push_back(1'b1);
    for (int i = 0; i < 10; i++) begin
      step(0, 100);
      check(err == 1'b1, "R7", err, 1, "err sticky");
      check(out_valid == 1'b0, "R7", out_valid, 0, "no word after overflow");
    end
    bitq.delete();
    chk_err = 1'b1;
  endtask

  initial begin
    do_reset();

    // R4: B = 0 words equal the zero count
    cur_req = "R4";
    push_id(0);
    push_word(0, 0);   push_word(0, 255); push_word(0, 1);  push_word(0, 128);
    push_word(0, 37);  push_word(0, 200); push_word(0, 3);  push_word(0, 64);
    drain(0, 100);

    // R3: every nonzero B with all-ones low bits and bound words
    cur_req = "R3";
    for (int b = 1; b < 8; b++) begin
      push_id(b);
      push_word(b, 0);
      push_word(b, 255);
      push_word(b, (1 << b) - 1);
      push_word(b, 1 << b);
      for (int k = 0; k < 4; k++) push_word(b, $urandom_range(255));
    end
    drain(0, 100);

    // R2: identifier changes between groups
    cur_req = "R2";
    for (int g = 0; g < 6; g++) rand_group($urandom_range(7));
    drain(0, 100);

    // R8: input gaps with noise bits and output stalls
    cur_req = "R8";
    for (int g = 0; g < 4; g++) rand_group($urandom_range(7));
    drain(40, 50);

    err_case(0);
    err_case(5);
    err_case(7);

    do_reset();
    cur_req = "R5";
    rand_group(6);
    rand_group(3);
    drain(20, 70);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule